// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block places one scan cell beside every pin of a design and links the cells into a single serial path. It has a scan input and a scan output. Each cell holds two registers: a scan stage that can capture or shift, and an update latch. A parameter vector makes each position either an input-pin cell or an output-pin cell. An input-pin cell sits between a pad and the core. An output-pin cell sits between the core and a pad.

All strobes come from an external test-access controller: capture, shift, update and a test-mode select. With test mode low, every cell passes its functional signal straight through. Scan activity can still run behind it without disturbing the pins. With test mode high, each update latch drives the far side of its cell. An input-pin cell drives the value seen by the core. An output-pin cell drives the pad. A capture strobe lets software read back what the pads or the core present.

Top module: `bscan_chain`

## Requirements
- R1: While `rst` is high at a clock edge, all scan stages, update latches and `conflict_err` clear to 0. Right after reset, `scan_out` is 0, and with `test_mode`=1 every used output bit reads 0.
- R2: With `test_mode`=0, input-pin cell i drives `to_core[i]` = `pad_in[i]` and output-pin cell i drives `to_pad[i]` = `core_out[i]`, combinationally, whatever the strobes do.
- R3: Bit i of `to_pad` is constant 0 for an input-pin cell, and bit i of `to_core` is constant 0 for an output-pin cell.
- R4: On a rising edge with `shift_en`=1 and `capture_en`=0, stage 0 takes `scan_in` and stage i takes stage i-1. `scan_out` always shows the last stage, so a bit appears there after NUM_CELLS shifts.
- R5: On a rising edge with `capture_en`=1, all stages load at once. An input-pin cell loads `pad_in[i]` and an output-pin cell loads `core_out[i]`.
- R6: When `capture_en` and `shift_en` are both 1 at an edge, the capture is performed and `conflict_err` is 1 during the next cycle. Otherwise `conflict_err` is 0 after that edge.
- R7: The update latches load from the scan stages only on an edge with `update_en`=1 and otherwise hold. With `test_mode`=1, `to_core` (input-pin cells) and `to_pad` (output-pin cells) show the latch, so shifting alone leaves them unchanged.
- R8: When `update_en` coincides with a shift or capture, the latches take the stage values from before that edge.
- R9: Bit i of parameter CELL_IS_OUT set to 1 makes cell i an output-pin cell, and 0 makes it an input-pin cell. The default, 8'hF0, puts input cells at positions 0-3 and output cells at positions 4-7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| capture_en | input | 1 | Parallel capture strobe |
| shift_en | input | 1 | Serial shift strobe |
| update_en | input | 1 | Update-latch load strobe |
| test_mode | input | 1 | 1 = latches drive the pins, 0 = functional pass-through |
| scan_in | input | 1 | Serial data into stage 0 |
| pad_in | input | NUM_CELLS | Pad values, used at input-pin positions |
| core_out | input | NUM_CELLS | Core values, used at output-pin positions |
| to_core | output | NUM_CELLS | Values to the core, input-pin positions |
| to_pad | output | NUM_CELLS | Values to the pads, output-pin positions |
| scan_out | output | 1 | Last stage of the chain |
| conflict_err | output | 1 | Capture and shift were requested on the previous edge |

## Verification
Random strobe mixes are applied with test mode both low and high against a reference model. This separates pass-through behaviour from latch-driven behaviour and shows whether shifting leaks onto the pins. A directed capture uses different pad and core patterns, then shifts the captured word out serially. That checks each position's capture source and the order of the chain. Directed cycles with capture and shift together, and with update alongside a shift, check conflict priority and the use of stage values from before the edge.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
        logic test_mode;
    } bs_ctrl_t;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_CAPTURE = 2'd2
    } stage_op_e;

    // capture has priority over shift
    function automatic stage_op_e decode_op(input bs_ctrl_t c);
        if (c.capture)
            return OP_CAPTURE;
        else if (c.shift)
            return OP_SHIFT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/bscan_ctrl.sv
`timescale 1ns/1ps
module bscan_ctrl
    import bscan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture_en,
    input  logic      shift_en,
    input  logic      update_en,
    input  logic      test_mode,
    output stage_op_e op,
    output logic      upd,
    output logic      tmode,
    output logic      conflict_err
);
    bs_ctrl_t ctrl;

    always_comb begin
        ctrl.capture   = capture_en;
        ctrl.shift     = shift_en;
        ctrl.update    = update_en;
        ctrl.test_mode = test_mode;
    end

    assign op    = decode_op(ctrl);
    assign upd   = ctrl.update;
    assign tmode = ctrl.test_mode;

    always_ff @(posedge clk) begin
        if (rst)
            conflict_err <= 1'b0;
        else
            conflict_err <= ctrl.capture & ctrl.shift;
    end

    // R6
    conflict_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (capture_en && shift_en) |=> conflict_err);

    // R6
    conflict_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !(capture_en && shift_en) |=> !conflict_err);

endmodule

// File: rtl/bscan_cell.sv
`timescale 1ns/1ps
module bscan_cell
    import bscan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  stage_op_e op,
    input  logic      upd,
    input  logic      tmode,
    input  logic      func_in,
    input  logic      scan_prev,
    output logic      stage_q,
    output logic      func_out
);
    logic upd_q;
    logic stage_d;

    always_comb begin
        unique case (op)
            OP_CAPTURE: stage_d = func_in;
            OP_SHIFT:   stage_d = scan_prev;
            default:    stage_d = stage_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= 1'b0;
            upd_q   <= 1'b0;
        end else begin
            stage_q <= stage_d;
            if (upd)
                upd_q <= stage_q;
        end
    end

    assign func_out = tmode ? upd_q : func_in;

    // R5
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CAPTURE) |=> (stage_q == $past(func_in)));

    // R4
    shift_load_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (stage_q == $past(scan_prev)));

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(upd_q));

    // R8
    latch_old_stage_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> (upd_q == $past(stage_q)));

endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int                   NUM_CELLS   = 8,
    parameter logic [NUM_CELLS-1:0] CELL_IS_OUT = 8'hF0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture_en,
    input  logic                 shift_en,
    input  logic                 update_en,
    input  logic                 test_mode,
    input  logic                 scan_in,
    input  logic [NUM_CELLS-1:0] pad_in,
    input  logic [NUM_CELLS-1:0] core_out,
    output logic [NUM_CELLS-1:0] to_core,
    output logic [NUM_CELLS-1:0] to_pad,
    output logic                 scan_out,
    output logic                 conflict_err
);
    localparam int LAST = NUM_CELLS - 1;

    stage_op_e            op;
    logic                 upd;
    logic                 tmode;
    logic [NUM_CELLS-1:0] stage;
    logic [NUM_CELLS-1:0] prev;
    logic [NUM_CELLS-1:0] cell_in;
    logic [NUM_CELLS-1:0] cell_out;

    bscan_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .capture_en   (capture_en),
        .shift_en     (shift_en),
        .update_en    (update_en),
        .test_mode    (test_mode),
        .op           (op),
        .upd          (upd),
        .tmode        (tmode),
        .conflict_err (conflict_err)
    );

    assign prev = {stage[LAST-1:0], scan_in};

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        if (CELL_IS_OUT[i]) begin : g_out
            assign cell_in[i] = core_out[i];
            assign to_pad[i]  = cell_out[i];
            assign to_core[i] = 1'b0;
        end else begin : g_in
            assign cell_in[i] = pad_in[i];
            assign to_core[i] = cell_out[i];
            assign to_pad[i]  = 1'b0;
        end

        bscan_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .op        (op),
            .upd       (upd),
            .tmode     (tmode),
            .func_in   (cell_in[i]),
            .scan_prev (prev[i]),
            .stage_q   (stage[i]),
            .func_out  (cell_out[i])
        );
    end

    assign scan_out = stage[LAST];

    // R3
    unused_side_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((to_pad & ~CELL_IS_OUT) == '0) && ((to_core & CELL_IS_OUT) == '0));

    // R7
    pins_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (test_mode && !update_en) |=> (test_mode -> ($stable(to_core) && $stable(to_pad))));

endmodule

// File: tb/test_bscan_chain.sv
`timescale 1ns/1ps
module test_bscan_chain;
    localparam int           N      = 8;
    localparam logic [N-1:0] IS_OUT = 8'hF0;

    logic         clk = 1'b0;
    logic         rst;
    logic         capture_en, shift_en, update_en, test_mode, scan_in;
    logic [N-1:0] pad_in, core_out;
    logic [N-1:0] to_core, to_pad;
    logic         scan_out, conflict_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [N-1:0] sc_m, up_m;
    logic         err_m;

    always #4 clk = ~clk;

    bscan_chain #(.NUM_CELLS(N), .CELL_IS_OUT(IS_OUT)) i_bscan_chain (
        .clk(clk), .rst(rst), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .test_mode(test_mode), .scan_in(scan_in),
        .pad_in(pad_in), .core_out(core_out), .to_core(to_core), .to_pad(to_pad),
        .scan_out(scan_out), .conflict_err(conflict_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_core(input logic md, input logic [N-1:0] p);
        return (md ? up_m : p) & ~IS_OUT;
    endfunction

    function automatic logic [N-1:0] exp_pad(input logic md, input logic [N-1:0] co);
        return (md ? up_m : co) & IS_OUT;
    endfunction

    // one clock: drive at negedge, check, step model at posedge
    task automatic cyc(input logic c, input logic s, input logic u, input logic m,
                       input logic si, input logic [N-1:0] p, input logic [N-1:0] co);
        capture_en = c; shift_en = s; update_en = u; test_mode = m;
        scan_in = si; pad_in = p; core_out = co;
        #1;
        chk(m ? "R7 to_core" : "R2 to_core", 32'(to_core), 32'(exp_core(m, p)));
        chk(m ? "R7 to_pad" : "R2 to_pad", 32'(to_pad), 32'(exp_pad(m, co)));
        chk("R3 unused sides", 32'((to_pad & ~IS_OUT) | (to_core & IS_OUT)), 32'd0);
        chk("R4 scan_out", 32'(scan_out), 32'(sc_m[N-1]));
        chk("R6 conflict_err", 32'(conflict_err), 32'(err_m));
        @(posedge clk);
        if (u) up_m = sc_m;
        if (c) sc_m = (co & IS_OUT) | (p & ~IS_OUT);
        else if (s) sc_m = {sc_m[N-2:0], si};
        err_m = c & s;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] word;
        void'($urandom(32'd1234));
        rst = 1'b1;
        capture_en = 0; shift_en = 0; update_en = 0; test_mode = 0;
        scan_in = 0; pad_in = '0; core_out = '0;
        sc_m = '0; up_m = '0; err_m = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, latches seen in test mode
        test_mode = 1; pad_in = 8'hFF; core_out = 8'hFF; #1;
        chk("R1 scan_out", 32'(scan_out), 0);
        chk("R1 conflict_err", 32'(conflict_err), 0);
        chk("R1 to_core", 32'(to_core), 0);
        chk("R1 to_pad", 32'(to_pad), 0);
        @(negedge clk);

        // R5 R9 capture from distinct sources, then shift out
        cyc(1, 0, 0, 0, 0, 8'hA5, 8'h3C);
        word = '0;
        for (int k = 0; k < N; k++) begin
            word[N-1-k] = scan_out;
            cyc(0, 1, 0, 0, 0, 8'h00, 8'h00);
        end
        chk("R5 R9 captured word", 32'(word), 32'h35);

        // R7 load latches in test mode, then shift without update
        for (int k = 0; k < N; k++) cyc(0, 1, 0, 1, k[0], 8'h0F, 8'hF0);
        cyc(0, 0, 1, 1, 0, 8'h0F, 8'hF0);
        chk("R7 latched to_core", 32'(to_core), 32'(8'h55 & ~IS_OUT));
        for (int k = 0; k < 4; k++) cyc(0, 1, 0, 1, 1, 8'h0F, 8'hF0);
        chk("R7 pins after shifting", 32'(to_pad), 32'(8'h55 & IS_OUT));

        // R8 update with shift on same edge takes old stages
        cyc(0, 1, 1, 1, 0, 8'h00, 8'h00);
        chk("R8 latch old stage", 32'(to_core | to_pad), 32'(8'h5F));

        // R6 capture and shift together
        cyc(1, 1, 0, 0, 1, 8'h0C, 8'hC0);
        chk("R6 conflict flag", 32'(conflict_err), 1);
        cyc(0, 0, 0, 0, 0, 8'h00, 8'h00);
        chk("R6 flag clears", 32'(conflict_err), 0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] r;
            r = 4'($urandom);
            cyc((r[1:0] == 0), ($urandom_range(0, 2) != 0), (r[3:2] == 0),
                1'($urandom), 1'($urandom), N'($urandom), N'($urandom));
        end

        // R1 reset mid-run
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        sc_m = '0; up_m = '0; err_m = 0;
        test_mode = 1; #1;
        chk("R1 reset again", 32'(to_core | to_pad), 0);
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule